// File: doc/BRIEF.md
# Ping-Pong Bulk-IN Endpoint Buffer

This block is the data path of a device-side bulk-IN endpoint. It holds two packet buffers of 64 bytes each, and the two buffers take turns. The application pushes bytes through a single byte port and never chooses a buffer. Each commit strobe closes exactly one packet and moves the fill side to the other buffer. The serial engine reports each IN token to the block. If a committed packet is waiting, the block streams it out, one byte per clock. If none is waiting, it answers with a NAK pulse.

A packet stays in its buffer until the host acknowledges it. A timeout leaves the packet in place so that the next token sends it again. Two hardware-set flags tell software when to act. The space flag is set after reset and whenever a buffer is released. The request flag is set by a NAK. A sticky overflow flag records dropped bytes. Software clears any flag by writing 0 to its bit. A registered interrupt combines each flag with its enable.

Top module: `bulk_in_pingpong`

## Requirements
- R1: After reset both buffers are free, emptyFlag is 1, xferFlag, ovfFlag, irq, nakPulse, pktStart and txValid are 0.
- R2: Bytes presented with wrValid go in order into the buffer being filled. pktCommit closes only that one buffer, with a length equal to the bytes stored so far. A byte presented in the commit cycle is included as the packet's last byte. Filling then moves to the other buffer, so 128 bytes followed by one commit yield a single packet.
- R3: An inToken while idle with no committed packet gives nakPulse=1 for one cycle on the next clock edge, and xferFlag is set on the same edge.
- R4: An inToken while idle with a committed packet gives pktStart=1 with pktLen on the next edge. The packet bytes then appear on txData with txValid on consecutive cycles, starting in the pktStart cycle, and txLast marks the final byte. A zero-length packet gives pktStart with pktLen=0 and no txValid.
- R5: Committed packets are sent in commit order, alternating between the two buffers.
- R6: Bytes beyond 64 in one packet are dropped, and so are bytes written while the fill buffer still holds an unsent packet. Each drop sets ovfFlag. A commit while both buffers hold packets is ignored.
- R7: hostAck after a packet frees its buffer and sets emptyFlag. hostTimeout keeps the packet, and the next inToken resends the same bytes.
- R8: A flag write with flagWrEn clears a flag whose bit is 0 and leaves a flag whose bit is 1 unchanged. The bits are: bit 0 = emptyFlag, bit 1 = xferFlag, bit 2 = ovfFlag.
- R9: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R10: irq is a register that takes (emptyFlag AND emptyIe) OR (xferFlag AND xferIe) each clock, so it follows the flags one cycle later.
- R11: inToken during a send or while waiting for the host is ignored. hostAck and hostTimeout have no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Byte write strobe from the application |
| wrData | input | 8 | Byte to write |
| pktCommit | input | 1 | Close the packet being filled |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 3 | Flag keep mask: 0 clears, 1 keeps |
| emptyIe | input | 1 | Interrupt enable for emptyFlag |
| xferIe | input | 1 | Interrupt enable for xferFlag |
| inToken | input | 1 | IN token seen by the serial engine |
| hostAck | input | 1 | Host acknowledged the last packet |
| hostTimeout | input | 1 | Host did not acknowledge |
| nakPulse | output | 1 | Answer NAK to the token |
| pktStart | output | 1 | First cycle of a packet transmission |
| pktLen | output | 7 | Length of the packet being sent |
| txValid | output | 1 | txData carries a packet byte |
| txData | output | 8 | Packet byte to the serial engine |
| txLast | output | 1 | Final byte of the packet |
| emptyFlag | output | 1 | A buffer has room for a packet |
| xferFlag | output | 1 | A token found no data |
| ovfFlag | output | 1 | Sticky: a byte was dropped |
| irq | output | 1 | Registered combined interrupt |

## Verification
A software flag clear can land in the same cycle as a hardware set of that flag. This happens for the request flag when an IN token is answered with a NAK, and for the space flag when the host acknowledges a packet. The bench places a clearing flag write on exactly the cycle where the token or the acknowledge is presented. It then reads the flag on the following cycle and expects it to be 1. A separate check confirms that a plain clearing write, with no set pending, does reach 0.

// File: rtl/ppep_pkg.sv
package ppep_pkg;
  typedef enum logic [1:0] {EP_IDLE, EP_SEND, EP_WAIT} epState_t;

  typedef struct packed {
    logic wrByte;
    logic commit;
    logic wrSel;
    logic rdSel;
    logic rdLoad;
    logic rdStep;
  } epStrobe_t;
endpackage

// File: rtl/ppep_datapath.sv
module ppep_datapath
  import ppep_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int DATA_W = 8,
  localparam int LEN_W = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  epStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAtCap,
  output logic [LEN_W-1:0]  curLen,
  output logic [DATA_W-1:0] txData,
  output logic              rdAtLast,
  output logic              lenZero
);
  logic [LEN_W-1:0] wrCnt;
  logic [LEN_W-1:0] rdIdx;
  logic [1:0][LEN_W-1:0] lenAll;
  logic [1:0][DATA_W-1:0] byteAll;

  // fill counter for the buffer currently being written
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrCnt <= '0;
    else if (strb.commit) wrCnt <= '0;
    else if (strb.wrByte) wrCnt <= wrCnt + LEN_W'(1);
  end

  // read index for the packet being streamed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdIdx <= '0;
    else if (strb.rdLoad) rdIdx <= '0;
    else if (strb.rdStep) rdIdx <= rdIdx + LEN_W'(1);
  end

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [DATA_W-1:0] mem [BUF_BYTES];
    logic [LEN_W-1:0]  lenReg;
    logic              selW;
    assign selW = (b == 1) ? strb.wrSel : !strb.wrSel;

    always_ff @(posedge clk) begin
      if (strb.wrByte && selW) mem[wrCnt[ADDR_W-1:0]] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lenReg <= '0;
      else if (strb.commit && selW) lenReg <= wrCnt + LEN_W'(strb.wrByte);
    end

    assign lenAll[b]  = lenReg;
    assign byteAll[b] = mem[rdIdx[ADDR_W-1:0]];
  end

  assign wrAtCap  = (wrCnt == LEN_W'(BUF_BYTES));
  assign curLen   = lenAll[strb.rdSel];
  assign txData   = byteAll[strb.rdSel];
  assign lenZero  = (curLen == '0);
  assign rdAtLast = ((rdIdx + LEN_W'(1)) == curLen);
endmodule

// File: rtl/ppep_control.sv
module ppep_control
  import ppep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       pktCommit,
  input  logic       flagWrEn,
  input  logic [2:0] flagWrData,
  input  logic       emptyIe,
  input  logic       xferIe,
  input  logic       inToken,
  input  logic       hostAck,
  input  logic       hostTimeout,
  input  logic       wrAtCap,
  input  logic       rdAtLast,
  input  logic       lenZero,
  output epStrobe_t  strb,
  output logic       nakPulse,
  output logic       pktStart,
  output logic       txValid,
  output logic       txLast,
  output logic       emptyFlag,
  output logic       xferFlag,
  output logic       ovfFlag,
  output logic       irq
);
  epState_t state;
  logic [1:0] full;
  logic wrSel, rdSel;
  logic canWrite, tokAccept, tokNak, relBuf, sendDone, ovfSet;
  logic [1:0] setMask, clrMask;

  always_comb begin
    canWrite    = !full[wrSel];
    strb.wrSel  = wrSel;
    strb.rdSel  = rdSel;
    strb.wrByte = wrValid && canWrite && !wrAtCap;
    strb.commit = pktCommit && canWrite;
    tokAccept   = (state == EP_IDLE) && inToken && full[rdSel];
    tokNak      = (state == EP_IDLE) && inToken && !full[rdSel];
    strb.rdLoad = tokAccept;
    strb.rdStep = (state == EP_SEND) && !lenZero;
    sendDone    = (state == EP_SEND) && (lenZero || rdAtLast);
    relBuf      = (state == EP_WAIT) && hostAck;
    ovfSet      = wrValid && !strb.wrByte;
    txValid     = (state == EP_SEND) && !lenZero;
    txLast      = txValid && rdAtLast;
    setMask     = {strb.commit && wrSel, strb.commit && !wrSel};
    clrMask     = {relBuf && rdSel, relBuf && !rdSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= EP_IDLE;
      full     <= '0;
      wrSel    <= 1'b0;
      rdSel    <= 1'b0;
      nakPulse <= 1'b0;
      pktStart <= 1'b0;
    end else begin
      full     <= (full | setMask) & ~clrMask;
      nakPulse <= tokNak;
      pktStart <= tokAccept;
      if (strb.commit) wrSel <= !wrSel;
      if (relBuf) rdSel <= !rdSel;
      unique case (state)
        EP_IDLE: if (tokAccept) state <= EP_SEND;
        EP_SEND: if (sendDone) state <= EP_WAIT;
        EP_WAIT: if (hostAck || hostTimeout) state <= EP_IDLE;
        default: state <= EP_IDLE;
      endcase
    end
  end

  // hardware set takes precedence over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag <= 1'b1;
      xferFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      emptyFlag <= relBuf || (emptyFlag && !(flagWrEn && !flagWrData[0]));
      xferFlag  <= tokNak || (xferFlag && !(flagWrEn && !flagWrData[1]));
      ovfFlag   <= ovfSet || (ovfFlag && !(flagWrEn && !flagWrData[2]));
      irq       <= (emptyFlag && emptyIe) || (xferFlag && xferIe);
    end
  end
endmodule

// File: rtl/bulk_in_pingpong.sv
module bulk_in_pingpong
  import ppep_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int DATA_W = 8,
  localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pktCommit,
  input  logic              flagWrEn,
  input  logic [2:0]        flagWrData,
  input  logic              emptyIe,
  input  logic              xferIe,
  input  logic              inToken,
  input  logic              hostAck,
  input  logic              hostTimeout,
  output logic              nakPulse,
  output logic              pktStart,
  output logic [LEN_W-1:0]  pktLen,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              txLast,
  output logic              emptyFlag,
  output logic              xferFlag,
  output logic              ovfFlag,
  output logic              irq
);
  epStrobe_t strb;
  logic wrAtCap, rdAtLast, lenZero;

  ppep_control u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .pktCommit(pktCommit),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .emptyIe(emptyIe),
    .xferIe(xferIe), .inToken(inToken), .hostAck(hostAck),
    .hostTimeout(hostTimeout), .wrAtCap(wrAtCap), .rdAtLast(rdAtLast),
    .lenZero(lenZero), .strb(strb), .nakPulse(nakPulse), .pktStart(pktStart),
    .txValid(txValid), .txLast(txLast), .emptyFlag(emptyFlag),
    .xferFlag(xferFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  ppep_datapath #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wrAtCap(wrAtCap), .curLen(pktLen), .txData(txData),
    .rdAtLast(rdAtLast), .lenZero(lenZero)
  );
endmodule

// File: rtl/bulk_in_pingpong_checker.sv
module bulk_in_pingpong_checker #(
  parameter int BUF_BYTES = 64,
  localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             nakPulse,
  input logic             pktStart,
  input logic [LEN_W-1:0] pktLen,
  input logic             txValid,
  input logic             txLast,
  input logic             emptyFlag,
  input logic             xferFlag,
  input logic             emptyIe,
  input logic             xferIe,
  input logic             irq
);
  p_nak_no_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    nakPulse |-> !pktStart);

  p_nak_sets_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    nakPulse |-> xferFlag);

  p_last_is_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  p_stream_contiguous_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txLast) |=> txValid);

  p_len_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |-> (int'(pktLen) <= BUF_BYTES));

  p_irq_raise_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((emptyFlag && emptyIe) || (xferFlag && xferIe)) |=> irq);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!(emptyFlag && emptyIe) && !(xferFlag && xferIe)) |=> !irq);
endmodule

bind bulk_in_pingpong bulk_in_pingpong_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .nakPulse(nakPulse), .pktStart(pktStart),
  .pktLen(pktLen), .txValid(txValid), .txLast(txLast),
  .emptyFlag(emptyFlag), .xferFlag(xferFlag), .emptyIe(emptyIe),
  .xferIe(xferIe), .irq(irq)
);

// File: tb/tb_bulk_in_pingpong.sv
module tb_bulk_in_pingpong;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, pktCommit = 1'b0, flagWrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] flagWrData = 3'b111;
  logic emptyIe = 1'b0, xferIe = 1'b0;
  logic inToken = 1'b0, hostAck = 1'b0, hostTimeout = 1'b0;
  logic nakPulse, pktStart, txValid, txLast, emptyFlag, xferFlag, ovfFlag, irq;
  logic [6:0] pktLen;
  logic [7:0] txData;
  int checks = 0;
  int fails = 0;

  always #4 clk = !clk;

  bulk_in_pingpong dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .pktCommit(pktCommit), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .emptyIe(emptyIe), .xferIe(xferIe), .inToken(inToken), .hostAck(hostAck),
    .hostTimeout(hostTimeout), .nakPulse(nakPulse), .pktStart(pktStart),
    .pktLen(pktLen), .txValid(txValid), .txData(txData), .txLast(txLast),
    .emptyFlag(emptyFlag), .xferFlag(xferFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writePkt(int n, int base, bit commitWithLast);
    for (int i = 0; i < n; i++) begin
      wrValid = 1'b1;
      wrData = 8'(base + i);
      pktCommit = commitWithLast && (i == n - 1);
      tick();
    end
    wrValid = 1'b0;
    if (!commitWithLast) begin
      pktCommit = 1'b1;
      tick();
    end
    pktCommit = 1'b0;
  endtask

  task automatic token();
    inToken = 1'b1;
    tick();
    inToken = 1'b0;
  endtask

  task automatic flagWrite(logic [2:0] keep);
    flagWrEn = 1'b1;
    flagWrData = keep;
    tick();
    flagWrEn = 1'b0;
    flagWrData = 3'b111;
  endtask

  task automatic pulseAck();
    hostAck = 1'b1;
    tick();
    hostAck = 1'b0;
  endtask

  // called right after token(): checks the whole streamed packet
  task automatic expectPkt(string req, int n, int base);
    chk({req, " pktStart"}, int'(pktStart), 1);
    chk({req, " pktLen"}, int'(pktLen), n);
    chk({req, " no nak"}, int'(nakPulse), 0);
    if (n == 0) begin
      chk({req, " zlp txValid"}, int'(txValid), 0);
      tick();
    end else begin
      for (int i = 0; i < n; i++) begin
        chk({req, " txValid"}, int'(txValid), 1);
        chk({req, " txData"}, int'(txData), (base + i) & 8'hFF);
        chk({req, " txLast"}, int'(txLast), (i == n - 1) ? 1 : 0);
        tick();
      end
    end
    chk({req, " idle after packet"}, int'(txValid), 0);
  endtask

  task automatic expectNak(string req);
    token();
    chk({req, " nakPulse"}, int'(nakPulse), 1);
    chk({req, " no pktStart"}, int'(pktStart), 0);
    chk({req, " xferFlag"}, int'(xferFlag), 1);
    tick();
    chk({req, " nak single cycle"}, int'(nakPulse), 0);
    flagWrite(3'b101);
  endtask

  task automatic testReset();
    chk("R1 emptyFlag", int'(emptyFlag), 1);
    chk("R1 xferFlag", int'(xferFlag), 0);
    chk("R1 ovfFlag", int'(ovfFlag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 nakPulse", int'(nakPulse), 0);
    chk("R1 pktStart", int'(pktStart), 0);
    chk("R1 txValid", int'(txValid), 0);
  endtask

  task automatic testIrq();
    emptyIe = 1'b1;
    tick();
    chk("R10 irq on enable", int'(irq), 1);
    flagWrite(3'b110);
    chk("R8 empty cleared", int'(emptyFlag), 0);
    chk("R10 irq lags flag", int'(irq), 1);
    tick();
    chk("R10 irq drops", int'(irq), 0);
    emptyIe = 1'b0;
    xferIe = 1'b1;
    token();
    chk("R3 nak", int'(nakPulse), 1);
    chk("R10 irq not yet", int'(irq), 0);
    tick();
    chk("R10 irq from xfer", int'(irq), 1);
    xferIe = 1'b0;
    flagWrite(3'b101);
    tick();
    chk("R10 irq off", int'(irq), 0);
  endtask

  task automatic testNakFlags();
    expectNak("R3");
    chk("R8 xfer cleared", int'(xferFlag), 0);
    token();
    flagWrite(3'b111);
    chk("R8 write 1 keeps", int'(xferFlag), 1);
    flagWrite(3'b101);
    chk("R8 write 0 clears", int'(xferFlag), 0);
    // set and clear of xferFlag in the same cycle
    inToken = 1'b1;
    flagWrEn = 1'b1;
    flagWrData = 3'b101;
    tick();
    inToken = 1'b0;
    flagWrEn = 1'b0;
    flagWrData = 3'b111;
    chk("R9 nak set wins", int'(xferFlag), 1);
    flagWrite(3'b101);
  endtask

  task automatic testBasic();
    writePkt(3, 8'h10, 1'b0);
    token();
    expectPkt("R4 basic", 3, 8'h10);
    chk("R7 empty low before ack", int'(emptyFlag), 0);
    pulseAck();
    chk("R7 ack sets empty", int'(emptyFlag), 1);
    expectNak("R7 freed");
    writePkt(2, 8'h40, 1'b1);
    token();
    expectPkt("R2 byte with commit", 2, 8'h40);
    pulseAck();
  endtask

  task automatic testRetry();
    writePkt(4, 8'h20, 1'b0);
    pulseAck();
    hostTimeout = 1'b1;
    tick();
    hostTimeout = 1'b0;
    token();
    expectPkt("R11 ack idle ignored", 4, 8'h20);
    token();
    chk("R11 token in wait no nak", int'(nakPulse), 0);
    chk("R11 token in wait no start", int'(pktStart), 0);
    hostTimeout = 1'b1;
    tick();
    hostTimeout = 1'b0;
    token();
    expectPkt("R7 resend", 4, 8'h20);
    pulseAck();
  endtask

  task automatic testOrder();
    flagWrite(3'b011);
    writePkt(5, 8'h50, 1'b0);
    writePkt(6, 8'h60, 1'b0);
    chk("R6 ovf clean", int'(ovfFlag), 0);
    writePkt(2, 8'hA0, 1'b0);
    chk("R6 ovf when full", int'(ovfFlag), 1);
    token();
    expectPkt("R5 first", 5, 8'h50);
    pulseAck();
    token();
    expectPkt("R5 second", 6, 8'h60);
    pulseAck();
    expectNak("R6 commit ignored");
  endtask

  task automatic testOverflow();
    flagWrite(3'b011);
    chk("R8 ovf cleared", int'(ovfFlag), 0);
    writePkt(128, 8'h80, 1'b0);
    chk("R6 ovf past cap", int'(ovfFlag), 1);
    token();
    expectPkt("R2 one commit one packet", 64, 8'h80);
    pulseAck();
    expectNak("R2 no second packet");
  endtask

  task automatic testZlp();
    writePkt(0, 0, 1'b0);
    token();
    expectPkt("R4 zero length", 0, 0);
    flagWrite(3'b110);
    chk("R8 empty cleared", int'(emptyFlag), 0);
    hostAck = 1'b1;
    flagWrEn = 1'b1;
    flagWrData = 3'b110;
    tick();
    hostAck = 1'b0;
    flagWrEn = 1'b0;
    flagWrData = 3'b111;
    chk("R9 release set wins", int'(emptyFlag), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testIrq();
    testNakFlags();
    testBasic();
    testRetry();
    testOrder();
    testOverflow();
    testZlp();
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule